// File: doc/BRIEF.md
# Self-Disarming Alarm Comparator Bank

This block holds a small set of one-shot alarms that watch the low 32-bit word of a free-running time base supplied from outside. Software programs an alarm by writing its 32-bit target over a simple register bus. That write also arms the alarm. When the live time word equals the target exactly, the alarm fires once, records an interrupt event and disarms itself. Software can cancel any armed alarm early by writing ones to a shared armed-status register.

Fire events collect in a sticky raw interrupt register. Software clears it by writing ones. An enable mask and a force register combine with the raw bits to form the interrupt status, and one interrupt line per alarm follows that status. The time base and its tick generation sit outside the block. Bus reads are combinational in the cycle `bus_sel` is high with `bus_wr` low, and writes take effect at the clock edge.

Top module: `alarm_match_bank`

## Requirements
- R1: After reset all armed, raw, enable and force bits read as zero, every interrupt line is low, and each target register reads zero.
- R2: A write to the target register of alarm i (byte address 0x10 + 4*i) stores the value, which reads back at the same address, and sets bit i of the armed register (address 0x20) at that edge.
- R3: An armed alarm fires when `time_lo` equals its target at a clock edge, which sets raw bit i (address 0x34) at that edge. A time one above or one below the target does not fire it.
- R4: A firing alarm clears its own armed bit, and it does not fire again when the time matches later.
- R5: Writing a one to bit i of the armed register disarms alarm i without a fire, and bits written as zero leave the armed state unchanged. A disarm written in the cycle of a match suppresses that fire.
- R6: A disarmed alarm never fires, even when its stored target equals the live time.
- R7: When a target write lands in the same cycle as that alarm's match, the write wins. The alarm stays armed with the new target and no raw bit is set.
- R8: A raw bit stays set until a one is written to it at address 0x34, and zeros written there have no effect. A fire in the same cycle as a clear leaves the bit set.
- R9: The status register (address 0x40) reads (raw AND enable) OR force per bit, and writes to it are ignored. Enable is at 0x38 and force is at 0x3C, with bit i belonging to alarm i.
- R10: `irq[i]` equals status bit i. Setting force bit i raises `irq[i]` with no alarm activity and with the enable bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_lo | input | 32 | Live low word of the time base |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when idle or unmapped |
| irq | output | 4 | Per-alarm interrupt lines |

## Verification
A vector table drives each channel with targets at both ends of the word range (all zeros, all ones, top bit only) and presents times equal to, one above and one below the target. This separates an equality compare from a greater-or-equal or off-by-one compare, and shows that each channel decodes its own address. Directed sequences then place competing events in one cycle: a target rewrite against a match, a disarm against a match, and a raw clear against a fire. Their outcomes tell which side has priority. Force and mask patterns separate the raw path from the status and interrupt path.

// File: rtl/alarm_bank_pkg.sv
package alarm_bank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  // Byte addresses of the register map
  localparam addr_t OFF_TARGET0 = 8'h10;
  localparam addr_t OFF_ARMED   = 8'h20;
  localparam addr_t OFF_RAW     = 8'h34;
  localparam addr_t OFF_ENABLE  = 8'h38;
  localparam addr_t OFF_FORCE   = 8'h3C;
  localparam addr_t OFF_STATUS  = 8'h40;
endpackage

// File: rtl/alarm_channel.sv
module alarm_channel #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] time_lo,
  input  logic         tgt_wr,
  input  logic [W-1:0] tgt_wdata,
  input  logic         disarm,
  output logic [W-1:0] target,
  output logic         armed,
  output logic         fire
);
  logic [W-1:0] target_q;
  logic         armed_q, armed_d;

  // A target write or a disarm in the same cycle overrides a match
  always_comb begin
    fire    = armed_q && (time_lo == target_q) && !tgt_wr && !disarm;
    armed_d = armed_q;
    if (tgt_wr)              armed_d = 1'b1;
    else if (disarm || fire) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      target_q <= '0;
    else if (tgt_wr) target_q <= tgt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign target = target_q;
  assign armed  = armed_q;

  // R2
  a_r2_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr |=> (armed_q && target_q == $past(tgt_wdata)));
  // R4
  a_r4_self_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q);
  // R5
  a_r5_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm && !tgt_wr) |=> !armed_q);
  // R6
  a_r6_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !fire);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  input  logic [N-1:0] raw_clr,
  input  logic         en_wr,
  input  logic         frc_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] enable,
  output logic [N-1:0] force_q,
  output logic [N-1:0] status
);
  logic [N-1:0] raw_q, raw_d, en_q, frc_q;

  // A fire beats a clear of the same bit, so no event is lost
  always_comb raw_d = (raw_q & ~raw_clr) | fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frc_q <= '0;
    else if (frc_wr) frc_q <= wdata;
  end

  assign raw     = raw_q;
  assign enable  = en_q;
  assign force_q = frc_q;
  assign status  = (raw_q & en_q) | frc_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8
    a_r8_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[i] && !raw_clr[i]) |=> raw_q[i]);
    // R3
    a_r3_fire_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> raw_q[i]);
  end
endmodule

// File: rtl/alarm_match_bank.sv
module alarm_match_bank
  import alarm_bank_pkg::*;
#(
  parameter int unsigned N_CH = 4   // at most 4: target slots end below the armed register
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] time_lo,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   irq
);
  localparam int unsigned PAD_W = DATA_W - N_CH;

  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic wr_act, rd_act;
  assign wr_act = bus_sel && bus_wr;
  assign rd_act = bus_sel && !bus_wr;

  logic [N_CH-1:0]   tgt_wr, armed, fire, disarm, raw_clr;
  logic [DATA_W-1:0] target [N_CH];
  logic [N_CH-1:0]   raw, enable, force_q, status;

  assign disarm  = (wr_act && bus_addr == OFF_ARMED) ? bus_wdata[N_CH-1:0] : '0;
  assign raw_clr = (wr_act && bus_addr == OFF_RAW)   ? bus_wdata[N_CH-1:0] : '0;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign tgt_wr[i] = wr_act && (bus_addr == OFF_TARGET0 + ADDR_W'(4 * i));
    alarm_channel #(.W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .time_lo   (time_lo),
      .tgt_wr    (tgt_wr[i]),
      .tgt_wdata (bus_wdata),
      .disarm    (disarm[i]),
      .target    (target[i]),
      .armed     (armed[i]),
      .fire      (fire[i])
    );
  end

  alarm_irq_ctrl #(.N(N_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (fire),
    .raw_clr (raw_clr),
    .en_wr   (wr_act && bus_addr == OFF_ENABLE),
    .frc_wr  (wr_act && bus_addr == OFF_FORCE),
    .wdata   (bus_wdata[N_CH-1:0]),
    .raw     (raw),
    .enable  (enable),
    .force_q (force_q),
    .status  (status)
  );

  assign irq = status;

  always_comb begin
    bus_rdata = '0;
    if (rd_act) begin
      for (int i = 0; i < N_CH; i++)
        if (bus_addr == OFF_TARGET0 + ADDR_W'(4 * i)) bus_rdata = target[i];
      case (bus_addr)
        OFF_ARMED:  bus_rdata = {{PAD_W{1'b0}}, armed};
        OFF_RAW:    bus_rdata = {{PAD_W{1'b0}}, raw};
        OFF_ENABLE: bus_rdata = {{PAD_W{1'b0}}, enable};
        OFF_FORCE:  bus_rdata = {{PAD_W{1'b0}}, force_q};
        OFF_STATUS: bus_rdata = {{PAD_W{1'b0}}, status};
        default: ;
      endcase
    end
  end

  // R10: a set force bit shows on its line one edge after the write
  a_r10_force_raises: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_act && bus_addr == OFF_FORCE) |=> ((irq & $past(bus_wdata[N_CH-1:0])) == $past(bus_wdata[N_CH-1:0])));
  // R7
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tgt_wr != '0) |-> ((fire & tgt_wr) == '0));
endmodule

// File: tb/alarm_match_bank_tb.sv
module alarm_match_bank_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] IDLE_T = 32'h5555_0000;
  localparam int NV = 6;
  localparam int          V_CH    [NV] = '{0, 1, 2, 3, 3, 1};
  localparam logic [31:0] V_TGT   [NV] = '{32'h0000_1000, 32'h0000_2000, 32'hFFFF_FFFF,
                                           32'h0000_0000, 32'h1234_5678, 32'h8000_0000};
  localparam logic [31:0] V_PROBE [NV] = '{32'h0000_1000, 32'h0000_2001, 32'hFFFF_FFFF,
                                           32'h0000_0000, 32'h1234_5677, 32'h8000_0000};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] time_lo;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  alarm_match_bank u_dut (
    .clk(clk), .rst_n(rst_n), .time_lo(time_lo), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge with the bus idle
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] t);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; time_lo = t;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; time_lo = IDLE_T;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic probe(input logic [31:0] t);
    time_lo = t;
    @(posedge clk); @(negedge clk);
    time_lo = IDLE_T;
  endtask

  task automatic wipe();
    wr(8'h20, 32'hF, IDLE_T);
    wr(8'h34, 32'hF, IDLE_T);
    wr(8'h38, 32'h0, IDLE_T);
    wr(8'h3C, 32'h0, IDLE_T);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; time_lo = IDLE_T; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h20, d); chk("R1 armed", d, 0);
    rd(8'h34, d); chk("R1 raw", d, 0);
    rd(8'h38, d); chk("R1 enable", d, 0);
    rd(8'h3C, d); chk("R1 force", d, 0);
    rd(8'h10, d); chk("R1 target0", d, 0);
    chk("R1 irq", {28'd0, irq}, 0);

    // Vector table: equality vs neighbours, per channel
    for (int v = 0; v < NV; v++) begin
      logic [7:0] ta;
      logic hit;
      ta  = 8'h10 + 8'(4 * V_CH[v]);
      hit = (V_TGT[v] == V_PROBE[v]);
      wr(ta, V_TGT[v], IDLE_T);
      rd(ta, d);    chk("R2 target readback", d, V_TGT[v]);
      rd(8'h20, d); chk("R2 armed bit", d, 32'(1) << V_CH[v]);
      probe(V_PROBE[v]);
      rd(8'h34, d); chk("R3 raw after probe", d, hit ? (32'(1) << V_CH[v]) : 0);
      rd(8'h20, d); chk("R4 armed after probe", d, hit ? 0 : (32'(1) << V_CH[v]));
      wipe();
    end

    // R4/R10/R8: fire once, irq follows, clear, no refire
    wr(8'h38, 32'h1, IDLE_T);
    wr(8'h10, 32'h100, IDLE_T);
    probe(32'h100);
    chk("R10 irq after fire", {28'd0, irq}, 32'h1);
    wr(8'h34, 32'h1, IDLE_T);
    rd(8'h34, d); chk("R8 raw cleared by one", d, 0);
    probe(32'h100);
    rd(8'h34, d); chk("R4 no second fire", d, 0);
    wipe();

    // R8: zeros written to raw do nothing
    wr(8'h18, 32'h200, IDLE_T);
    probe(32'h200);
    wr(8'h34, 32'h0, IDLE_T);
    rd(8'h34, d); chk("R8 raw zero write ignored", d, 32'h4);
    wipe();

    // R5/R6: early disarm, zero write no effect, stale target silent
    wr(8'h14, 32'h300, IDLE_T);
    wr(8'h20, 32'h0, IDLE_T);
    rd(8'h20, d); chk("R5 zero write keeps armed", d, 32'h2);
    wr(8'h20, 32'h2, IDLE_T);
    rd(8'h20, d); chk("R5 disarm by one", d, 0);
    probe(32'h300);
    rd(8'h34, d); chk("R6 disarmed no fire", d, 0);
    wipe();

    // R5: disarm in the cycle of a match
    wr(8'h1C, 32'h400, IDLE_T);
    wr(8'h20, 32'h8, 32'h400);
    rd(8'h34, d); chk("R5 disarm beats match raw", d, 0);
    rd(8'h20, d); chk("R5 disarm beats match armed", d, 0);
    wipe();

    // R7: target write in the cycle of a match
    wr(8'h10, 32'h500, IDLE_T);
    wr(8'h10, 32'h600, 32'h500);
    rd(8'h34, d); chk("R7 no fire on rewrite", d, 0);
    rd(8'h20, d); chk("R7 still armed", d, 32'h1);
    rd(8'h10, d); chk("R7 new target", d, 32'h600);
    probe(32'h600);
    rd(8'h34, d); chk("R3 fires on new target", d, 32'h1);
    wipe();

    // R10/R9: force without enable, status read-only
    wr(8'h3C, 32'h4, IDLE_T);
    chk("R10 force raises irq", {28'd0, irq}, 32'h4);
    wr(8'h40, 32'hF, IDLE_T);
    rd(8'h40, d); chk("R9 status write ignored", d, 32'h4);
    wipe();

    // R9: masking of the raw bit
    wr(8'h14, 32'h700, IDLE_T);
    probe(32'h700);
    rd(8'h40, d); chk("R9 masked status", d, 0);
    chk("R10 masked irq", {28'd0, irq}, 0);
    wr(8'h38, 32'h2, IDLE_T);
    rd(8'h40, d); chk("R9 enabled status", d, 32'h2);
    chk("R10 enabled irq", {28'd0, irq}, 32'h2);
    wipe();

    // R8: fire and clear in one cycle keeps the bit
    wr(8'h18, 32'h800, IDLE_T);
    probe(32'h800);
    wr(8'h18, 32'h900, IDLE_T);
    wr(8'h34, 32'h4, 32'h900);
    rd(8'h34, d); chk("R8 fire beats clear", d, 32'h4);
    rd(8'h20, d); chk("R4 disarmed after fire", d, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule